// File: doc/BRIEF.md
# Receive FCS Checker and Stripper

This block sits on a receive datapath just after payload descrambling. It takes a byte stream of framed payload, marked with start-of-frame and end-of-frame flags, runs a 32-bit CRC over each frame and compares the result with the 32-bit frame check sequence that closes the frame. By default it also drops those four trailing bytes. The rest of the stream goes on towards the receive FIFO, with the end-of-frame flag moved back to the last payload byte.

A small 8-bit control register holds two switches that act independently of each other. One switch turns off error reporting. The other keeps the FCS bytes in the forwarded stream. As a result, software can verify the FCS and keep it, or remove it without checking it. A third bit is stored for a descrambler upstream and is only presented on an output pin. Each frame's error verdict comes out as a one-cycle flag on the forwarded end-of-frame byte.

Top module: `rx_fcs_filter`

## Requirements
- R1: The control register resets to 0x00 and reads back the last value written in bits 2..0, with bits 7..3 always reading zero. Bit 0 set means the FCS is kept, bit 1 set means the check is off, and bit 2 is driven on `scrBypass` and has no effect here.
- R2: The CRC uses generator 0x04C11DB7 and is preset to all ones at the first byte of a frame. Bytes are shifted in most significant bit first. A frame is good when the CRC over all bytes except the last four equals the bitwise inverse of those four bytes, taken as a 32-bit word with the earliest byte most significant.
- R3: When bit 0 is clear, the last four bytes of every frame are dropped. A forwarded byte leaves on the clock edge that accepts the input byte four positions later, and `outEof` marks the last payload byte. `outSof` marks the first forwarded byte.
- R4: When bit 0 is set, every input byte is forwarded on the clock edge after the edge that accepts it. Its data, `outSof` and `outEof` are unchanged.
- R5: When checking is on and a frame of at least four bytes fails the test of R2, `outFcsErr` is high for exactly one cycle, in the same cycle as that frame's `outEof`. Good frames never raise it.
- R6: When bit 1 is set, `outFcsErr` stays low for every frame, and the forwarded bytes and markers are identical to those produced with bit 1 clear.
- R7: A frame shorter than four bytes is flagged as an error when checking is on. When the FCS is stripped, a frame of four bytes or fewer forwards no byte. In that case any error flag appears with `outValid` low, one cycle after the end-of-frame byte is accepted.
- R8: Both control bits are sampled at the start-of-frame byte and hold for the whole frame. A write in the middle of a frame takes effect from the next frame.
- R9: Input bytes are accepted only while `inValid` is high, and idle cycles inside a frame do not change the result. `outValid` is high only in a cycle that follows an accepted byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Control register write strobe |
| regWrData | input | 8 | Control register write data |
| regRdData | output | 8 | Control register read data |
| scrBypass | output | 1 | Stored descrambler-off bit for the upstream stage |
| inValid | input | 1 | Input byte valid |
| inData | input | 8 | Input byte |
| inSof | input | 1 | Input byte is the first of a frame |
| inEof | input | 1 | Input byte is the last of a frame |
| outValid | output | 1 | Forwarded byte valid |
| outData | output | 8 | Forwarded byte |
| outSof | output | 1 | Forwarded byte starts a frame |
| outEof | output | 1 | Forwarded byte ends a frame |
| outFcsErr | output | 1 | One-cycle FCS error flag for the frame |

## Verification
The assertions assume a well-formed input stream. Every frame opens with `inSof` on its first accepted byte and closes with `inEof` on its last, and no byte is presented outside a frame. The assertions also assume that `inValid` is low from reset until the first frame. The directed stimulus builds every frame as a whole, from start marker to end marker, and holds `inValid` low during idle gaps and between scenarios. That also holds for frames of one to four bytes and for frames sent back to back. Register writes happen either between frames or, in the scenario for R8, on an ordinary mid-frame byte.

// File: rtl/rx_fcs_pkg.sv
package rx_fcs_pkg;

  // Strobes from the control unit to the datapath, one set per input cycle.
  typedef struct packed {
    logic accept;    // an input byte is taken this cycle
    logic restart;   // that byte opens a frame
    logic crcStep;   // the oldest buffered byte joins the CRC
    logic emitBuf;   // forward the oldest buffered byte (strip mode)
    logic emitIn;    // forward the input byte (keep mode)
    logic markSof;   // the forwarded byte is the first of its frame
    logic frameEnd;  // the input byte closes its frame
    logic shortFrm;  // the closing frame is shorter than its FCS
    logic checkOn;   // the error verdict is reported for this frame
  } fcsStrobes_t;

  localparam int REG_W = 8;
  localparam int CFG_W = 3;

endpackage

// File: rtl/rx_fcs_ctrl.sv
module rx_fcs_ctrl
  import rx_fcs_pkg::*;
#(
  parameter int FCS_BYTES = 4,
  parameter int CNT_W     = $clog2(FCS_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData,
  output logic             scrBypass,
  input  logic             inValid,
  input  logic             inSof,
  input  logic             inEof,
  output fcsStrobes_t      stb
);

  localparam logic [CNT_W-1:0] FULL_CNT  = CNT_W'(FCS_BYTES);
  localparam logic [CNT_W-1:0] SHORT_CNT = CNT_W'(FCS_BYTES - 1);

  logic [CFG_W-1:0] cfgQ;       // [0] keep FCS, [1] check off, [2] descrambler off
  logic             stripLat;
  logic             checkLat;
  logic [CNT_W-1:0] fillQ;
  logic             sofPend;

  logic             restart;
  logic             stripNow;
  logic             checkNow;
  logic [CNT_W-1:0] fillEff;
  logic             full;

  assign regRdData = {{(REG_W - CFG_W){1'b0}}, cfgQ};
  assign scrBypass = cfgQ[2];

  always_comb begin
    restart  = inValid && inSof;
    stripNow = restart ? !cfgQ[0] : stripLat;
    checkNow = restart ? !cfgQ[1] : checkLat;
    fillEff  = restart ? '0 : fillQ;
    full     = (fillEff == FULL_CNT);

    stb.accept   = inValid;
    stb.restart  = restart;
    stb.crcStep  = inValid && full;
    stb.emitBuf  = inValid && stripNow && full;
    stb.emitIn   = inValid && !stripNow;
    stb.markSof  = stripNow ? sofPend : inSof;
    stb.frameEnd = inValid && inEof;
    stb.shortFrm = inValid && inEof && (fillEff < SHORT_CNT);
    stb.checkOn  = checkNow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ     <= '0;
      stripLat <= 1'b1;
      checkLat <= 1'b1;
      fillQ    <= '0;
      sofPend  <= 1'b0;
    end else begin
      if (regWrEn) cfgQ <= regWrData[CFG_W-1:0];
      if (restart) begin
        stripLat <= stripNow;
        checkLat <= checkNow;
      end
      if (inValid) begin
        if (inEof)      fillQ <= '0;
        else if (!full) fillQ <= fillEff + CNT_W'(1);
        else            fillQ <= FULL_CNT;
      end
      if (stb.frameEnd)    sofPend <= 1'b0;
      else if (stb.emitBuf) sofPend <= 1'b0;
      else if (restart)     sofPend <= 1'b1;
    end
  end

endmodule

// File: rtl/rx_fcs_dpath.sv
module rx_fcs_dpath
  import rx_fcs_pkg::*;
#(
  parameter int              CRC_W    = 32,
  parameter logic [CRC_W-1:0] CRC_POLY = 32'h04C11DB7,
  parameter int              BYTE_W   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  fcsStrobes_t       stb,
  input  logic [BYTE_W-1:0] inData,
  output logic              outValid,
  output logic [BYTE_W-1:0] outData,
  output logic              outSof,
  output logic              outEof,
  output logic              outFcsErr
);

  localparam int FCS_BYTES = CRC_W / BYTE_W;
  localparam int LAST      = FCS_BYTES - 1;

  logic [BYTE_W-1:0] bufQ [FCS_BYTES];
  logic [CRC_W-1:0]  crcQ;
  logic [CRC_W-1:0]  crcBase;
  logic [CRC_W-1:0]  crcNext;
  logic [CRC_W-1:0]  fcsRx;
  logic              mismatch;

  // Serial CRC update over one byte, most significant bit first.
  function automatic logic [CRC_W-1:0] crcByte(input logic [CRC_W-1:0] c,
                                               input logic [BYTE_W-1:0] d);
    logic [CRC_W-1:0] r;
    logic             fb;
    r = c;
    for (int b = BYTE_W - 1; b >= 0; b--) begin
      fb = r[CRC_W-1] ^ d[b];
      r  = {r[CRC_W-2:0], 1'b0};
      if (fb) r = r ^ CRC_POLY;
    end
    return r;
  endfunction

  always_comb begin
    crcBase = stb.restart ? '1 : crcQ;
    crcNext = stb.crcStep ? crcByte(crcBase, bufQ[LAST]) : crcBase;
    fcsRx   = '0;
    fcsRx[BYTE_W-1:0] = inData;
    for (int k = 0; k < LAST; k++) begin
      fcsRx[BYTE_W*(k+1) +: BYTE_W] = bufQ[k];
    end
    mismatch = (crcNext != ~fcsRx);
  end

  generate
    for (genvar g = 0; g < FCS_BYTES; g++) begin : gStage
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)           bufQ[g] <= '0;
        else if (stb.accept) bufQ[g] <= (g == 0) ? inData : bufQ[(g == 0) ? 0 : g - 1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      crcQ      <= '1;
      outValid  <= 1'b0;
      outData   <= '0;
      outSof    <= 1'b0;
      outEof    <= 1'b0;
      outFcsErr <= 1'b0;
    end else begin
      if (stb.accept) crcQ <= crcNext;
      outValid  <= stb.emitBuf || stb.emitIn;
      outData   <= stb.emitBuf ? bufQ[LAST] : inData;
      outSof    <= (stb.emitBuf || stb.emitIn) && stb.markSof;
      outEof    <= stb.frameEnd && (stb.emitBuf || stb.emitIn);
      outFcsErr <= stb.frameEnd && stb.checkOn && (stb.shortFrm || mismatch);
    end
  end

endmodule

// File: rtl/rx_fcs_filter.sv
module rx_fcs_filter
  import rx_fcs_pkg::*;
#(
  parameter int               CRC_W    = 32,
  parameter logic [CRC_W-1:0] CRC_POLY = 32'h04C11DB7
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWrEn,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  output logic       scrBypass,
  input  logic       inValid,
  input  logic [7:0] inData,
  input  logic       inSof,
  input  logic       inEof,
  output logic       outValid,
  output logic [7:0] outData,
  output logic       outSof,
  output logic       outEof,
  output logic       outFcsErr
);

  localparam int FCS_BYTES = CRC_W / 8;

  fcsStrobes_t stb;

  rx_fcs_ctrl #(.FCS_BYTES(FCS_BYTES)) uCtrl (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
    .scrBypass(scrBypass),
    .inValid(inValid), .inSof(inSof), .inEof(inEof),
    .stb(stb)
  );

  rx_fcs_dpath #(.CRC_W(CRC_W), .CRC_POLY(CRC_POLY), .BYTE_W(8)) uDpath (
    .clk(clk), .rstN(rstN), .stb(stb), .inData(inData),
    .outValid(outValid), .outData(outData), .outSof(outSof),
    .outEof(outEof), .outFcsErr(outFcsErr)
  );

endmodule

// File: rtl/rx_fcs_check.sv
module rx_fcs_check (
  input logic       clk,
  input logic       rstN,
  input logic       regWrEn,
  input logic [7:0] regWrData,
  input logic [7:0] regRdData,
  input logic       inValid,
  input logic       inEof,
  input logic       outValid,
  input logic       outEof,
  input logic       outFcsErr
);

  assert_rsvd_zero_R1: assert property (@(posedge clk) disable iff (!rstN)
    regRdData[7:3] == 5'd0);

  assert_write_visible_R1: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> regRdData[2:0] == $past(regWrData[2:0]));

  assert_out_after_in_R9: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(inValid));

  assert_eof_valid_R3: assert property (@(posedge clk) disable iff (!rstN)
    outEof |-> outValid);

  assert_err_on_eof_R5: assert property (@(posedge clk) disable iff (!rstN)
    outFcsErr |-> (outEof || !outValid));

  assert_err_after_end_R7: assert property (@(posedge clk) disable iff (!rstN)
    outFcsErr |-> $past(inValid && inEof));

endmodule

bind rx_fcs_filter rx_fcs_check uCheck (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
  .regRdData(regRdData), .inValid(inValid), .inEof(inEof),
  .outValid(outValid), .outEof(outEof), .outFcsErr(outFcsErr)
);

// File: tb/rx_fcs_filter_test.sv
`timescale 1ns/1ps
module rx_fcs_filter_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic       scrBypass;
  logic       inValid = 1'b0;
  logic [7:0] inData = '0;
  logic       inSof = 1'b0;
  logic       inEof = 1'b0;
  logic       outValid;
  logic [7:0] outData;
  logic       outSof;
  logic       outEof;
  logic       outFcsErr;

  always #4 clk = ~clk;

  rx_fcs_filter uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .scrBypass(scrBypass),
    .inValid(inValid), .inData(inData), .inSof(inSof), .inEof(inEof),
    .outValid(outValid), .outData(outData), .outSof(outSof),
    .outEof(outEof), .outFcsErr(outFcsErr)
  );

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 0;

  logic [7:0] frm [0:63];
  int         frmLen;

  logic [7:0] expD [0:255];
  bit         expS [0:255];
  bit         expE [0:255];
  bit         expR [0:255];
  int         expN;
  int         expLone;

  logic [7:0] capD [0:255];
  bit         capS [0:255];
  bit         capE [0:255];
  bit         capR [0:255];
  int         capN;
  int         capLone;
  bit         capOn = 0;

  function automatic logic [31:0] crcStep8(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r = c;
    for (int b = 7; b >= 0; b--) begin
      if (r[31] ^ d[b]) r = {r[30:0], 1'b0} ^ 32'h04C11DB7;
      else              r = {r[30:0], 1'b0};
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      finishRun();
    end
  end

  always @(negedge clk) begin
    if (capOn) begin
      if (outValid) begin
        capD[capN] = outData;
        capS[capN] = outSof;
        capE[capN] = outEof;
        capR[capN] = outFcsErr;
        capN++;
      end else if (outFcsErr) begin
        capLone++;
      end
    end
  end

  task automatic clearAll();
    expN = 0; expLone = 0; capN = 0; capLone = 0;
    for (int i = 0; i < 256; i++) begin
      expS[i] = 0; expE[i] = 0; expR[i] = 0;
    end
    capOn = 1;
  endtask

  // payload of payLen bytes followed by a correct FCS (MSB byte first), optional corruption
  task automatic buildFrame(input int payLen, input int seed, input bit corrupt);
    logic [31:0] c = 32'hFFFF_FFFF;
    logic [31:0] f;
    for (int i = 0; i < payLen; i++) begin
      frm[i] = 8'((seed * 7 + i * 13 + 5) & 255);
      c = crcStep8(c, frm[i]);
    end
    f = ~c;
    frm[payLen]     = f[31:24];
    frm[payLen + 1] = f[23:16];
    frm[payLen + 2] = f[15:8];
    frm[payLen + 3] = f[7:0];
    frmLen = payLen + 4;
    if (corrupt) frm[payLen + 1] = frm[payLen + 1] ^ 8'h10;
  endtask

  task automatic buildRaw(input int len, input int seed);
    for (int i = 0; i < len; i++) frm[i] = 8'((seed * 11 + i * 3) & 255);
    frmLen = len;
  endtask

  task automatic expectFrame(input bit strip, input bit check);
    int n;
    bit bad;
    int first;
    logic [31:0] c;
    logic [31:0] f;
    bad = 0;
    if (frmLen < 4) bad = 1;
    else begin
      c = 32'hFFFF_FFFF;
      for (int i = 0; i < frmLen - 4; i++) c = crcStep8(c, frm[i]);
      f = {frm[frmLen-4], frm[frmLen-3], frm[frmLen-2], frm[frmLen-1]};
      bad = (c != ~f);
    end
    bad = bad && check;
    n = strip ? frmLen - 4 : frmLen;
    if (n < 0) n = 0;
    first = expN;
    for (int i = 0; i < n; i++) begin
      expD[expN] = frm[i];
      expS[expN] = (i == 0);
      expE[expN] = (i == n - 1);
      expR[expN] = (i == n - 1) && bad;
      expN++;
    end
    if (n == 0 && bad) expLone++;
    if (first < 0) expLone = expLone;
  endtask

  task automatic sendFrame(input int gapMask, input int wrAt, input logic [7:0] wrVal);
    for (int i = 0; i < frmLen; i++) begin
      if (i < 32 && gapMask[i]) begin
        inValid = 0; inSof = 0; inEof = 0;
        @(negedge clk);
      end
      inValid = 1;
      inData  = frm[i];
      inSof   = (i == 0);
      inEof   = (i == frmLen - 1);
      regWrEn = (i == wrAt);
      regWrData = wrVal;
      @(negedge clk);
      regWrEn = 0;
    end
  endtask

  task automatic idle(input int n);
    inValid = 0; inSof = 0; inEof = 0;
    repeat (n) @(negedge clk);
  endtask

  task automatic regWrite(input logic [7:0] v);
    regWrEn = 1; regWrData = v;
    @(negedge clk);
    regWrEn = 0;
  endtask

  task automatic compareCap(input string req);
    int badD = 0, badM = 0, badR = 0;
    idle(4);
    capOn = 0;
    chk(capN == expN, {req, " forwarded byte count"}, capN, expN);
    for (int i = 0; i < expN && i < capN; i++) begin
      if (capD[i] != expD[i]) badD++;
      if (capS[i] != expS[i] || capE[i] != expE[i]) badM++;
      if (capR[i] != expR[i]) badR++;
    end
    chk(badD == 0, {req, " data mismatches"}, badD, 0);
    chk(badM == 0, {req, " sof/eof marker mismatches"}, badM, 0);
    chk(badR == 0, {req, " error flag placement mismatches"}, badR, 0);
    chk(capLone == expLone, {req, " error flags without data"}, capLone, expLone);
  endtask

  // R1: reset state and register behaviour
  task automatic testRegister();
    chk(regRdData == 8'h00, "R1 reset value", regRdData, 0);
    chk(outValid == 0 && outFcsErr == 0, "R1 outputs idle after reset", outValid, 0);
    regWrite(8'hFF);
    chk(regRdData == 8'h07, "R1 reserved bits read zero", regRdData, 7);
    chk(scrBypass == 1, "R1 descrambler bit on pin", scrBypass, 1);
    regWrite(8'hF8);
    chk(regRdData == 8'h00, "R1 clear", regRdData, 0);
    chk(scrBypass == 0, "R1 descrambler bit cleared", scrBypass, 0);
  endtask

  // R2, R3: strip and check a good frame
  task automatic testStripGood();
    clearAll();
    buildFrame(10, 1, 0); expectFrame(1, 1); sendFrame(0, -1, 0);
    compareCap("R2 R3 strip good");
  endtask

  // R3: strip latency, byte 0 leaves on the edge accepting byte 4
  task automatic testStripLatency();
    buildFrame(6, 9, 0);
    inValid = 1; inSof = 1; inEof = 0; inData = frm[0];
    @(negedge clk);
    inSof = 0;
    for (int i = 1; i < 4; i++) begin
      inData = frm[i];
      @(negedge clk);
      chk(outValid == 0, "R3 no output while buffer fills", outValid, 0);
    end
    inData = frm[4];
    @(negedge clk);
    chk(outValid == 1 && outData == frm[0], "R3 first byte after four-byte delay", outData, frm[0]);
    for (int i = 5; i < frmLen; i++) begin
      inData = frm[i]; inEof = (i == frmLen - 1);
      @(negedge clk);
    end
    chk(outEof == 1 && outData == frm[5], "R3 eof on last payload byte", outData, frm[5]);
    idle(3);
  endtask

  // R5: corrupted frame flagged
  task automatic testStripBad();
    clearAll();
    buildFrame(12, 2, 1); expectFrame(1, 1); sendFrame(0, -1, 0);
    compareCap("R5 strip bad fcs");
  endtask

  // R4: keep mode passes every byte
  task automatic testKeep();
    regWrite(8'h01);
    clearAll();
    buildFrame(9, 3, 0); expectFrame(0, 1); sendFrame(0, -1, 0);
    buildFrame(7, 4, 1); expectFrame(0, 1); sendFrame(0, -1, 0);
    compareCap("R4 keep mode");
    regWrite(8'h00);
  endtask

  // R4 latency: one cycle
  task automatic testKeepLatency();
    regWrite(8'h01);
    inValid = 1; inSof = 1; inEof = 0; inData = 8'h5A;
    @(negedge clk);
    chk(outValid == 1 && outData == 8'h5A && outSof == 1, "R4 one-cycle forward", outData, 8'h5A);
    inSof = 0; inEof = 1; inData = 8'hC3;
    @(negedge clk);
    chk(outValid == 1 && outEof == 1 && outFcsErr == 1, "R4 R7 two-byte frame end flagged", outFcsErr, 1);
    idle(3);
    regWrite(8'h00);
  endtask

  // R9: idle gaps inside frames
  task automatic testGaps();
    clearAll();
    buildFrame(11, 5, 0); expectFrame(1, 1); sendFrame(32'h0000_2A52, -1, 0);
    buildFrame(8, 6, 1);  expectFrame(1, 1); sendFrame(32'h0000_0E01, -1, 0);
    compareCap("R9 gapped strip");
    regWrite(8'h01);
    clearAll();
    buildFrame(6, 7, 0); expectFrame(0, 1); sendFrame(32'h0000_0155, -1, 0);
    compareCap("R9 gapped keep");
    regWrite(8'h00);
  endtask

  // R6: check inhibit, both strip and keep
  task automatic testInhibit();
    regWrite(8'h02);
    clearAll();
    buildFrame(10, 8, 1); expectFrame(1, 0); sendFrame(0, -1, 0);
    buildRaw(2, 3);       expectFrame(1, 0); sendFrame(0, -1, 0);
    compareCap("R6 check off strip");
    regWrite(8'h03);
    clearAll();
    buildFrame(5, 10, 1); expectFrame(0, 0); sendFrame(0, -1, 0);
    compareCap("R6 check off keep");
    regWrite(8'h00);
  endtask

  // R7: short frames
  task automatic testShort();
    clearAll();
    buildRaw(2, 1); expectFrame(1, 1); sendFrame(0, -1, 0);
    buildRaw(1, 2); expectFrame(1, 1); sendFrame(0, -1, 0);
    buildFrame(0, 0, 0); expectFrame(1, 1); sendFrame(0, -1, 0);
    buildFrame(0, 0, 1); expectFrame(1, 1); sendFrame(0, -1, 0);
    buildFrame(1, 4, 0); expectFrame(1, 1); sendFrame(0, -1, 0);
    compareCap("R7 short frames strip");
    regWrite(8'h01);
    clearAll();
    buildRaw(3, 5); expectFrame(0, 1); sendFrame(0, -1, 0);
    compareCap("R7 short frame keep");
    regWrite(8'h00);
  endtask

  // R8: mid-frame write applies from the next frame
  task automatic testMidWrite();
    clearAll();
    buildFrame(8, 11, 0); expectFrame(1, 1); sendFrame(0, 3, 8'h03);
    buildFrame(8, 12, 1); expectFrame(0, 0); sendFrame(0, 2, 8'h00);
    buildFrame(6, 13, 1); expectFrame(1, 1); sendFrame(0, -1, 0);
    compareCap("R8 mid-frame write");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testRegister();
    testStripGood();
    testStripLatency();
    testStripBad();
    testKeep();
    testKeepLatency();
    testGaps();
    testInhibit();
    testShort();
    testMidWrite();
    done = 1;
    finishRun();
  end

endmodule